// File: doc/BRIEF.md
# Linearized State Checksum Monitor

This block watches a four-state, single-input fixed-point state variable filter and produces a checksum error stream for detecting soft errors. On every valid cycle it takes the filter's state register vector and its input sample. It forms a check value, which is the fixed linear estimate of the filter's dynamics pre-multiplied by a coding vector, and holds it for one step. On the next valid cycle the new state vector arrives. The block forms its coding-vector weighted sum and reports that sum minus the held check value as a signed error sample.

The filter is nonlinear, and the estimate is only a least-squares linear fit. The error stream is therefore a small nonzero signal in normal operation, and a later stage judges it against a threshold. All coefficients are fixed when the block is built. The parameter `ALT_CODE` picks the alternative coding vector. Words are W-bit two's complement with W/2 fractional bits (Q8 for the default W=16). The state bus packs s1 in bits [W-1:0], s2 in the next W bits, and so on up to s4.

Top module: `lin_checksum_monitor`

## Requirements
- R1: While reset is held and on the first cycle after its release, `err_valid_o` is 0 and `err_o` is 0.
- R2: On each cycle with `in_valid` high, the block registers the check value X·s + Y·u. For the default vector the Q8 coefficients are X = [76, -59, 77, -22] for s1..s4 and Y = 71.
- R3: A valid sample that follows an earlier valid sample yields, one clock later, err = floor((CV·s_new − check_prev) / 256). Here CV = [64, 64, 64, 64] in Q8, and the division rounds toward minus infinity.
- R4: With `ALT_CODE`=1 the coefficients are CV = [38, 38, -102, 64], X = [20, 94, 43, 35] and Y = 27, all Q8.
- R5: An error value outside the W-bit signed range is clamped to 32767 or -32768 and never wraps.
- R6: `err_valid_o` rises exactly one clock after the second valid sample following reset. The first valid sample after reset gives no output.
- R7: In a cycle with `in_valid` low, `err_valid_o` is 0 one clock later and `err_o` keeps its value. The held check value is also kept, so the next valid sample is paired with the last valid sample before the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The state vector and input sample are valid this cycle |
| state_i | input | 4*W | Filter state s1..s4, s1 in the lowest W bits |
| u_i | input | W | Filter input sample |
| err_o | output | W | Signed checksum error sample, Q(W/2) |
| err_valid_o | output | 1 | `err_o` holds a new sample |

## Verification
The bench checks two builds side by side, the default and the alternative coding vector. Both see the same stimulus, so any mix-up between the two coefficient sets shows up at once. A positive ramp, mixed-sign states and an input-only sample separate the state weights from the input weight. A tiny negative difference shows whether the rounding floors or truncates toward zero. Full-scale states of opposite sign drive the error into both clamps. Gaps in `in_valid` with junk on the data pins, and a reset in mid-stream, show whether the held check value is paired with the right new state.

// File: rtl/lin_checksum_monitor.sv
module lin_checksum_monitor #(
  parameter int W        = 16,
  parameter bit ALT_CODE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [4*W-1:0] state_i,
  input  logic [W-1:0]   u_i,
  output logic [W-1:0]   err_o,
  output logic           err_valid_o
);
  localparam int  NS    = 4;
  localparam int  FRAC  = W / 2;
  localparam int  AW    = 2 * W + 4;
  localparam real SCALE = real'(1 << FRAC);

  // fitted third row of the estimate; rows 1, 2, 4 are pure shifts (s1<-u, s2<-s1, s4<-s3)
  localparam real A31 = 0.1824, A32 = -0.9158, A33 = 0.2062, A34 = -0.3389, B3 = 0.1086;
  localparam real C1 = ALT_CODE ? 0.15 : 0.25;
  localparam real C2 = ALT_CODE ? 0.15 : 0.25;
  localparam real C3 = ALT_CODE ? -0.40 : 0.25;
  localparam real C4 = 0.25;

  function automatic logic signed [AW-1:0] fix(input real r);
    int m;
    m = (r >= 0.0) ? $rtoi(r * SCALE + 0.5) : -$rtoi(-r * SCALE + 0.5);
    return AW'(m);
  endfunction

  localparam logic signed [AW-1:0] KC [NS] = '{fix(C1), fix(C2), fix(C3), fix(C4)};
  localparam logic signed [AW-1:0] KX [NS] = '{fix(C2 + C3 * A31), fix(C3 * A32),
                                               fix(C3 * A33 + C4), fix(C3 * A34)};
  localparam logic signed [AW-1:0] KY      = fix(C1 + C3 * B3);
  localparam logic signed [AW-1:0] MAXV    = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV    = ~MAXV;

  logic signed [AW-1:0] chk_now, dat_now, chk_q, diff, sh;
  logic [W-1:0]         sat;
  logic                 primed;

  always_comb begin
    chk_now = KY * AW'($signed(u_i));
    dat_now = '0;
    for (int i = 0; i < NS; i++) begin
      chk_now = chk_now + KX[i] * AW'($signed(state_i[i*W +: W]));
      dat_now = dat_now + KC[i] * AW'($signed(state_i[i*W +: W]));
    end
  end

  assign diff = dat_now - chk_q;
  assign sh   = diff >>> FRAC;
  assign sat  = (sh > MAXV) ? MAXV[W-1:0] : (sh < MINV) ? MINV[W-1:0] : sh[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed      <= 1'b0;
      chk_q       <= '0;
      err_o       <= '0;
      err_valid_o <= 1'b0;
    end else begin
      err_valid_o <= in_valid & primed;
      if (in_valid) begin
        primed <= 1'b1;
        chk_q  <= chk_now;
        if (primed) err_o <= sat;
      end
    end
  end

  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_o |-> $past(in_valid)); // R7
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(err_o)); // R7
  AST_FIRST_SAMPLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed) |=> !err_valid_o); // R6
  AST_PAIR_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && primed) |=> err_valid_o); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && primed && !diff[AW-1]) |=> !err_o[W-1]); // R5
endmodule

// File: tb/tb_lin_checksum_monitor.sv
`timescale 1ns/1ps
module tb_lin_checksum_monitor;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [4*W-1:0] state_i = '0;
  logic [W-1:0] u_i = '0;
  logic [W-1:0] e0, e1;
  logic v0, v1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lin_checksum_monitor #(.W(W), .ALT_CODE(1'b0)) dut (.clk, .rst_n, .in_valid, .state_i, .u_i,
    .err_o(e0), .err_valid_o(v0));
  lin_checksum_monitor #(.W(W), .ALT_CODE(1'b1)) dut_alt (.clk, .rst_n, .in_valid, .state_i, .u_i,
    .err_o(e1), .err_valid_o(v1));

  // coefficients taken from R2, R3, R4
  longint CV0 [4] = '{64, 64, 64, 64};
  longint X0  [4] = '{76, -59, 77, -22};
  longint Y0 = 71;
  longint CV1 [4] = '{38, 38, -102, 64};
  longint X1  [4] = '{20, 94, 43, 35};
  longint Y1 = 27;

  bit primed_m = 0;
  longint chk0_m = 0, chk1_m = 0, last0 = 0, last1 = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clamp(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // drive one cycle at a negedge, check the result at the following negedge
  task automatic step(input bit vld, input longint s [4], input longint u, input string req);
    longint d0 = 0, d1 = 0, c0 = Y0 * u, c1 = Y1 * u, x0, x1;
    bit expv;
    in_valid = vld;
    for (int i = 0; i < 4; i++) state_i[i*W +: W] = W'(s[i]);
    u_i = W'(u);
    for (int i = 0; i < 4; i++) begin
      d0 += CV0[i] * s[i]; d1 += CV1[i] * s[i];
      c0 += X0[i] * s[i];  c1 += X1[i] * s[i];
    end
    expv = vld && primed_m;
    x0 = expv ? clamp((d0 - chk0_m) >>> 8) : last0;
    x1 = expv ? clamp((d1 - chk1_m) >>> 8) : last1;
    @(negedge clk);
    check({req, " valid"}, longint'(v0), longint'(expv));
    check({req, " valid alt"}, longint'(v1), longint'(expv));
    check({req, " err"}, longint'($signed(e0)), x0);
    check({req, " err alt"}, longint'($signed(e1)), x1);
    if (vld) begin primed_m = 1; chk0_m = c0; chk1_m = c1; end
    last0 = x0; last1 = x1;
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    check("R1 valid in reset", longint'(v0), 0);
    check("R1 err in reset", longint'($signed(e0)), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after release", longint'(v0 | v1), 0);
    check("R1 err after release", longint'($signed(e1)), 0);
    primed_m = 0; chk0_m = 0; chk1_m = 0; last0 = 0; last1 = 0;
  endtask

  task automatic t_first();
    step(1, '{256, 128, -64, 32}, 100, "R6 first sample silent");
    step(1, '{100, 256, 128, -64}, 50, "R6 R3 second sample emits");
  endtask

  task automatic t_patterns();
    step(1, '{1000, 2000, 3000, 4000}, 500, "R2 R3 ramp");
    step(1, '{500, 1000, -2000, 3000}, -700, "R2 R4 mixed");
    step(1, '{-900, 500, 1200, -2000}, 0, "R3 R4 mixed2");
    step(1, '{0, 0, 0, 0}, 12000, "R2 input only");
    step(1, '{0, 0, 0, 0}, 0, "R2 R4 input weight");
  endtask

  task automatic t_floor();
    step(1, '{0, 0, 0, 0}, 1, "R3 floor setup");
    step(1, '{0, 0, 0, 0}, 0, "R3 floor rounds down");
  endtask

  task automatic t_sat();
    step(1, '{-32768, 32767, -32768, 32767}, -32768, "R5 sat setup");
    step(1, '{32767, 32767, 32767, 32767}, 32767, "R5 positive clamp");
    step(1, '{32767, -32768, 32767, -32768}, 32767, "R5 sat setup2");
    step(1, '{-32768, -32768, -32768, -32768}, -32768, "R5 negative clamp");
    check("R5 clamp value", longint'($signed(e0)), -32768);
  endtask

  task automatic t_gap();
    step(1, '{300, -200, 100, 50}, 40, "R7 before gap");
    step(0, '{9999, -9999, 5555, 1234}, 3333, "R7 gap ignored");
    step(0, '{-7777, 2222, -1111, 30000}, -3333, "R7 gap ignored 2");
    step(1, '{400, 300, -200, 100}, 10, "R7 pairs across gap");
  endtask

  task automatic t_midreset();
    do_reset();
    step(1, '{1000, 1000, 1000, 1000}, 1000, "R6 first after reset");
    step(1, '{2000, -1000, 500, 0}, 0, "R6 R3 second after reset");
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_first();
    t_patterns();
    t_floor();
    t_sat();
    t_gap();
    t_midreset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule